// File: doc/BRIEF.md
# Divider Configuration Load Controller

This block holds the programming state of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 2-bit test selector. The divide values can be written in two ways. In parallel mode they are taken from static configuration pins. Because those pins can be strapped, a known divide ratio is in place from power-up. In serial mode a 13-bit frame is shifted in on a serial clock and then moved into the live registers under a serial load strobe. The test selector can only be written through the serial path.

All strobe handling runs in the serial-clock domain. The block samples both load inputs on each rising serial-clock edge, so every load, transfer and latch takes effect on a clock edge. A debug output picks one of several internal signals according to the test selector. A flag reports when the loaded feedback value lies outside the range in which the loop can lock.

Top module: `divcfg_loader`

## Requirements
- R1: While `par_load_n` is low, each rising `sclk` edge copies `m_pins` into `m_val` and `n_pins` into `n_code`. This also covers the edge at which `par_load_n` is first seen high, so the pin values present at that edge are the ones latched.
- R2: When `par_load_n` is high and `ser_load` stays low, `m_val`, `n_code` and `t_sel` do not change, even if the pins change.
- R3: In serial mode (`par_load_n` high, `ser_load` low), each rising `sclk` edge shifts `ser_data` into bit 0 of a 13-bit shift register, and the older bits move toward the MSB. The frame is sent MSB first as T1, T0, N1, N0, M8 … M0. One null slot comes before the frame, and the bit in that slot is shifted out and has no effect.
- R4: At the first `sclk` edge that sees `ser_load` high (with `par_load_n` high), the shift register contents are copied into the registers: bits 12:11 go to `t_sel`, bits 10:9 to `n_code` and bits 8:0 to `m_val`.
- R5: At each further edge with `ser_load` still high, the shift register advances by one bit and the registers take the shifted value. Serial data therefore passes straight through.
- R6: At the edge that sees `ser_load` low again, the registers latch their value and hold it, even while new serial bits are shifted in.
- R7: Parallel mode takes priority over a serial strobe. A parallel load leaves `t_sel` unchanged.
- R8: `test_out` is 0 whenever `par_load_n` is low. Otherwise it follows `t_sel`: 00 gives 0, 01 gives `ser_data`, 10 gives `mdiv_fb` and 11 gives `fout_clk`.
- R9: `m_unlockable` is 1 exactly when `m_val` is below 25 or above 31.
- R10: While `rst_n` is low, `t_sel` is 00, the shift register is 0, and `m_val`/`n_code` take the values on the parallel pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all sampling and register updates |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_n | input | 1 | Parallel load, low = pins pass through |
| ser_load | input | 1 | Serial transfer/latch strobe |
| ser_data | input | 1 | Serial frame data |
| m_pins | input | 9 | Parallel feedback divide value |
| n_pins | input | 2 | Parallel output divide code |
| mdiv_fb | input | 1 | Feedback divider output, for the debug mux |
| fout_clk | input | 1 | Output clock, for the debug mux |
| m_val | output | 9 | Loaded feedback divide value |
| n_code | output | 2 | Loaded output divide code |
| t_sel | output | 2 | Loaded test selector {T1,T0} |
| test_out | output | 1 | Debug output |
| m_unlockable | output | 1 | Feedback value outside the lockable range |

## Verification
The bench sends frames whose leading null bit is 1. A design with the frame length off by one would let that bit land in T1 and would flip the test selector. The bench holds the strobe high for an extra clock to confirm pass-through, which a design that latched on the rising strobe edge would miss. It then shifts more bits after the strobe falls, which would corrupt a design that kept loading. Both parallel and serial strobes are asserted together, and a selector of 11 is combined with a parallel pulse: a wrong priority would take serial data or keep the mux active. The range values 24, 25, 31 and 32 expose an off-by-one in either limit.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  parameter int M_W  = 9;
  parameter int N_W  = 2;
  parameter int T_W  = 2;
  parameter int M_LO = 25;
  parameter int M_HI = 31;
  localparam int FRAME_W = T_W + N_W + M_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  typedef logic [FRAME_W-1:0] frame_t;

  // advance a frame by one serial bit, newest bit at the LSB
  function automatic frame_t frame_shift(frame_t cur, logic din);
    return {cur[FRAME_W-2:0], din};
  endfunction

  function automatic cfg_t frame_to_cfg(frame_t f);
    return cfg_t'(f);
  endfunction

  function automatic logic m_out_of_range(logic [M_W-1:0] m);
    return (int'(m) < M_LO) || (int'(m) > M_HI);
  endfunction

  function automatic logic test_pick(logic [T_W-1:0] sel, logic par_mode,
                                     logic sdat, logic mfb, logic fclk);
    logic r;
    if (par_mode) r = 1'b0;
    else begin
      case (sel)
        2'b01:   r = sdat;
        2'b10:   r = mfb;
        2'b11:   r = fclk;
        default: r = 1'b0;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/divcfg_strobe_sync.sv
module divcfg_strobe_sync (
  input  logic sclk,
  input  logic rst_n,
  input  logic par_load_n,
  input  logic ser_load,
  output logic par_mode,
  output logic par_rise,
  output logic ser_rise,
  output logic ser_hold,
  output logic ser_fall,
  output logic shift_en
);
  logic par_q, ser_q;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      ser_q <= 1'b0;
    end else begin
      par_q <= par_load_n;
      ser_q <= ser_load;
    end
  end

  always_comb begin
    par_mode = !par_load_n;
    par_rise = par_load_n && !par_q;
    ser_rise = par_load_n && ser_load && !ser_q;
    ser_hold = par_load_n && ser_load && ser_q;
    ser_fall = par_load_n && !ser_load && ser_q;
    shift_en = (par_load_n && !ser_load) || ser_hold;
  end

  // strobe events are mutually exclusive
  assert_events_exclusive_R4: assert property (@(posedge sclk) disable iff (!rst_n)
    $countones({par_mode, ser_rise, ser_hold}) <= 1);
endmodule

// File: rtl/divcfg_shifter.sv
module divcfg_shifter
  import divcfg_pkg::*;
(
  input  logic   sclk,
  input  logic   rst_n,
  input  logic   shift_en,
  input  logic   ser_data,
  output frame_t sreg,
  output frame_t sreg_next
);
  always_comb sreg_next = frame_shift(sreg, ser_data);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)        sreg <= '0;
    else if (shift_en) sreg <= sreg_next;
  end

  assert_shift_lsb_R3: assert property (@(posedge sclk) disable iff (!rst_n)
    shift_en |=> (sreg[0] == $past(ser_data)));
  assert_shift_hold_R3: assert property (@(posedge sclk) disable iff (!rst_n)
    !shift_en |=> $stable(sreg));
endmodule

// File: rtl/divcfg_regs.sv
module divcfg_regs
  import divcfg_pkg::*;
(
  input  logic           sclk,
  input  logic           rst_n,
  input  logic           par_mode,
  input  logic           par_rise,
  input  logic           ser_rise,
  input  logic           ser_hold,
  input  logic           ser_fall,
  input  logic [M_W-1:0] m_pins,
  input  logic [N_W-1:0] n_pins,
  input  frame_t         sreg,
  input  frame_t         sreg_next,
  output cfg_t           cfg
);
  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg;
    if (par_mode || par_rise) begin
      cfg_d.m = m_pins;
      cfg_d.n = n_pins;
    end else if (ser_rise) begin
      cfg_d = frame_to_cfg(sreg);
    end else if (ser_hold) begin
      cfg_d = frame_to_cfg(sreg_next);
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.t <= '0;
      cfg.n <= n_pins;
      cfg.m <= m_pins;
    end else begin
      cfg <= cfg_d;
    end
  end

  assert_par_pass_R1: assert property (@(posedge sclk) disable iff (!rst_n)
    (par_mode || par_rise) |=> (cfg.m == $past(m_pins) && cfg.n == $past(n_pins)));
  assert_par_keeps_t_R7: assert property (@(posedge sclk) disable iff (!rst_n)
    par_mode |=> (cfg.t == $past(cfg.t)));
  assert_ser_transfer_R4: assert property (@(posedge sclk) disable iff (!rst_n)
    (ser_rise && !par_rise) |=> (cfg == $past(sreg)));
  assert_latched_hold_R6: assert property (@(posedge sclk) disable iff (!rst_n)
    (ser_fall && !par_rise) |=> $stable(cfg));
endmodule

// File: rtl/divcfg_test_mux.sv
module divcfg_test_mux
  import divcfg_pkg::*;
(
  input  logic [T_W-1:0] t_sel,
  input  logic           par_mode,
  input  logic           ser_data,
  input  logic           mdiv_fb,
  input  logic           fout_clk,
  output logic           test_out
);
  always_comb test_out = test_pick(t_sel, par_mode, ser_data, mdiv_fb, fout_clk);
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
(
  input  logic           sclk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic           ser_load,
  input  logic           ser_data,
  input  logic [M_W-1:0] m_pins,
  input  logic [N_W-1:0] n_pins,
  input  logic           mdiv_fb,
  input  logic           fout_clk,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_code,
  output logic [T_W-1:0] t_sel,
  output logic           test_out,
  output logic           m_unlockable
);
  logic   par_mode, par_rise, ser_rise, ser_hold, ser_fall, shift_en;
  frame_t sreg, sreg_next;
  cfg_t   cfg;

  divcfg_strobe_sync u_sync (
    .sclk(sclk), .rst_n(rst_n), .par_load_n(par_load_n), .ser_load(ser_load),
    .par_mode(par_mode), .par_rise(par_rise), .ser_rise(ser_rise),
    .ser_hold(ser_hold), .ser_fall(ser_fall), .shift_en(shift_en));

  divcfg_shifter u_shift (
    .sclk(sclk), .rst_n(rst_n), .shift_en(shift_en), .ser_data(ser_data),
    .sreg(sreg), .sreg_next(sreg_next));

  divcfg_regs u_regs (
    .sclk(sclk), .rst_n(rst_n), .par_mode(par_mode), .par_rise(par_rise),
    .ser_rise(ser_rise), .ser_hold(ser_hold), .ser_fall(ser_fall),
    .m_pins(m_pins), .n_pins(n_pins), .sreg(sreg), .sreg_next(sreg_next),
    .cfg(cfg));

  divcfg_test_mux u_mux (
    .t_sel(cfg.t), .par_mode(par_mode), .ser_data(ser_data),
    .mdiv_fb(mdiv_fb), .fout_clk(fout_clk), .test_out(test_out));

  always_comb begin
    m_val        = cfg.m;
    n_code       = cfg.n;
    t_sel        = cfg.t;
    m_unlockable = m_out_of_range(cfg.m);
  end

  assert_hold_idle_R2: assert property (@(posedge sclk) disable iff (!rst_n)
    (par_load_n && $past(par_load_n) && !ser_load) |=> $stable({t_sel, n_code, m_val}));
  assert_passthru_R5: assert property (@(posedge sclk) disable iff (!rst_n)
    (ser_hold) |=> ({t_sel, n_code, m_val} == $past(sreg_next)));
endmodule

// File: tb/divcfg_loader_tb_top.sv
module divcfg_loader_tb_top;
  logic clk = 0, rst_n = 0, pl_n = 0, sl = 0, sd = 0, mfb = 0, fck = 0;
  logic [8:0] mp = 9'd27;
  logic [1:0] np = 2'd1;
  logic [8:0] m_val; logic [1:0] n_code, t_sel; logic test_out, m_bad;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  divcfg_loader dut_i (
    .sclk(clk), .rst_n(rst_n), .par_load_n(pl_n), .ser_load(sl), .ser_data(sd),
    .m_pins(mp), .n_pins(np), .mdiv_fb(mfb), .fout_clk(fck),
    .m_val(m_val), .n_code(n_code), .t_sel(t_sel), .test_out(test_out),
    .m_unlockable(m_bad));

  // {m, n} parallel vectors
  localparam logic [10:0] PVEC [8] = '{
    {9'd25, 2'd0}, {9'd31, 2'd3}, {9'd24, 2'd2}, {9'd32, 2'd1},
    {9'd0,  2'd3}, {9'd511, 2'd0}, {9'd28, 2'd2}, {9'd256, 2'd1}};

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bad_m(int m); return (m < 25 || m > 31) ? 1 : 0; endfunction

  task automatic send_frame(logic [1:0] t, logic [1:0] n, logic [8:0] m);
    logic [12:0] f;
    f = {t, n, m};
    pl_n = 1; sl = 0;
    sd = 1; tick;                       // null slot, ignored (R3)
    for (int i = 12; i >= 0; i--) begin sd = f[i]; tick; end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [12:0] fx;
    // R10 reset
    tick; tick;
    chk("R10 m", m_val, 27); chk("R10 n", n_code, 1); chk("R10 t", t_sel, 0);
    mp = 9'd30; tick;
    chk("R10 m follows pins", m_val, 30);
    rst_n = 1; tick;

    // table walk: R1, R2, R9
    foreach (PVEC[i]) begin
      pl_n = 0; mp = PVEC[i][10:2]; np = PVEC[i][1:0]; tick;
      chk("R1 m", m_val, PVEC[i][10:2]); chk("R1 n", n_code, PVEC[i][1:0]);
      chk("R9 flag", m_bad, bad_m(PVEC[i][10:2]));
      chk("R8 par low", test_out, 0);
      pl_n = 1; tick; mp = ~mp; np = ~np; tick; tick;
      chk("R2 m held", m_val, PVEC[i][10:2]); chk("R2 n held", n_code, PVEC[i][1:0]);
    end

    // serial frame with T=01: R3 R4 R5 R6
    send_frame(2'b01, 2'b10, 9'd29);
    chk("R2 no load during shift", m_val, 9'd256);
    sl = 1; tick;
    chk("R4 m", m_val, 29); chk("R4 n", n_code, 2); chk("R4 t", t_sel, 1);
    chk("R3 null ignored", t_sel, 1);
    sd = 1; tick;
    fx = {2'b01, 2'b10, 9'd29}; fx = {fx[11:0], 1'b1};
    chk("R5 pass m", m_val, fx[8:0]); chk("R5 pass t", t_sel, fx[12:11]);
    sl = 0; sd = 0; tick; sd = 1; tick; tick;
    chk("R6 latched m", m_val, fx[8:0]); chk("R6 latched n", n_code, fx[10:9]);

    // R8 mux per selector
    send_frame(2'b01, 2'b00, 9'd26); sl = 1; tick; sl = 0;
    sd = 1; #0.5 chk("R8 t01 sd1", test_out, 1);
    sd = 0; #0.5 chk("R8 t01 sd0", test_out, 0);
    tick;
    send_frame(2'b10, 2'b00, 9'd26); sl = 1; tick; sl = 0;
    mfb = 1; #0.5 chk("R8 t10", test_out, 1); mfb = 0; #0.5 chk("R8 t10 lo", test_out, 0);
    tick;
    send_frame(2'b00, 2'b00, 9'd26); sl = 1; tick; sl = 0;
    sd = 1; mfb = 1; fck = 1; #0.5 chk("R8 t00", test_out, 0);
    tick;
    send_frame(2'b11, 2'b11, 9'd40); sl = 1; tick; sl = 0; tick;
    chk("R9 serial flag", m_bad, 1);
    fck = 1; #0.5 chk("R8 t11", test_out, 1);
    // R7 / R8: parallel wins, T untouched, mux forced low
    pl_n = 0; sl = 1; mp = 9'd25; np = 2'd0; #0.5 chk("R8 forced low", test_out, 0);
    tick;
    chk("R7 m from pins", m_val, 25); chk("R7 t kept", t_sel, 3);
    chk("R9 in range", m_bad, 0);
    pl_n = 1; sl = 0; tick;
    chk("R8 t11 restored", test_out, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule